// File: doc/BRIEF.md
# Converter Bus Control Sequencer

This block is the synchronous control front end of a successive-approximation converter that sits on a parallel host bus. It watches chip enable, an active-low chip select, a read/convert select line and a short-cycle address bit. A rising edge of the internal enable, taken while the select line asks for a conversion, starts a conversion of either full (12-bit) or short (8-bit) length. A busy flag is high for exactly that conversion.

The analog part is replaced by a stub. When the length-dependent cycle count has elapsed, a supplied 12-bit word is captured as the result. In short mode the four least significant bits of that word are cleared. Reads return the result through a 12-bit data bus with an output-enable flag, which stands in for tristate pads. A format input selects either one full-width transfer or two byte-wide transfers chosen by the address bit.

During a conversion the block ignores control activity. The one exception is a fresh start edge: it re-latches the address bit, and that can lengthen or shorten the conversion already under way.

Top module: `adc_bus_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it is released, busy is low, oe_o is low and dbus_o is zero. A read made right after reset returns a zero result.
- R2: A conversion starts when enable (ce_i high and cs_n_i low) goes from false to true while rc_i is low and busy is low. busy_o goes high on the next clock edge. Holding enable high does not start a second conversion.
- R3: With the address bit latched as 0, busy_o stays high for exactly 12*CYC_PER_BIT clock cycles. With it latched as 1, busy_o stays high for exactly 8*CYC_PER_BIT cycles.
- R4: While busy_o is high, enable edges and changes on rc_i neither restart the conversion nor end it early. Its length is still counted from the original start.
- R5: A start edge that arrives while busy_o is high re-latches a0_i. The conversion then ends when the count for the new length is reached, counted from the original start.
- R6: oe_o is high only when rc_i is high, busy_o is low, ce_i is high and cs_n_i is low, all at once. Whenever oe_o is low, dbus_o is zero.
- R7: When fmt12_i is high during a read, dbus_o carries the whole 12-bit result.
- R8: When fmt12_i is low and a0_i is 0 during a read, dbus_o[11:4] carries result[11:4] and dbus_o[3:0] is zero.
- R9: When fmt12_i is low and a0_i is 1 during a read, dbus_o[11:8] carries result[3:0] and dbus_o[7:0] is zero.
- R10: sar_word_i is captured on the edge where busy_o falls. For a conversion that ends with the address bit latched as 1, bits [3:0] of the captured result are zero.
- R11: An enable edge taken while rc_i is high starts nothing. busy_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_i | input | 1 | Chip enable, active high |
| cs_n_i | input | 1 | Chip select, active low |
| rc_i | input | 1 | High selects read, low selects convert |
| a0_i | input | 1 | Short-cycle / byte address bit |
| fmt12_i | input | 1 | High selects full-width reads, low selects byte reads |
| sar_word_i | input | 12 | Stub result word captured when a conversion ends |
| busy_o | output | 1 | High only while a conversion is in progress |
| oe_o | output | 1 | Data bus output enable |
| dbus_o | output | 12 | Data bus, zero when not enabled |

## Verification
The bench builds the block with CYC_PER_BIT set to 2, so a full conversion lasts 24 cycles and a short one 16. That keeps every busy window short enough to be counted cycle by cycle, and it lets a re-latch land in the middle of a conversion. Because 2 is not 1, a length checked against the bit count alone would be caught. A re-latch at cycle 3 falls well below both limits, so both directions are reachable: a long conversion cut down to the short length, and a short one stretched to the full length.

// File: rtl/adc_bus_pkg.sv
package adc_bus_pkg;

    localparam int DATA_W  = 12;
    localparam int SHORT_W = 8;
    localparam int NIB_W   = DATA_W - SHORT_W;

    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_CONV = 1'b1
    } conv_st_e;

    // Clock cycles a conversion of the selected length occupies.
    function automatic int conv_cycles(input logic short_sel, input int cyc_per_bit);
        return (short_sel ? SHORT_W : DATA_W) * cyc_per_bit;
    endfunction

    // Clear the bits a short conversion never resolves.
    function automatic word_t trim_short(input word_t w, input logic short_sel);
        word_t r;
        r = w;
        if (short_sel) r[NIB_W-1:0] = '0;
        return r;
    endfunction

endpackage

// File: rtl/adc_en_edge.sv
module adc_en_edge (
    input  logic clk,
    input  logic rst,
    input  logic ce_i,
    input  logic cs_n_i,
    input  logic rc_i,
    output logic en_o,
    output logic start_o
);
    logic en_q;

    assign en_o    = ce_i & ~cs_n_i;
    assign start_o = en_o & ~en_q & ~rc_i;

    always_ff @(posedge clk) begin
        if (rst) en_q <= 1'b0;
        else     en_q <= en_o;
    end

    // R2: a start request is always a fresh enable edge
    assert_start_is_edge_R2: assert property (@(posedge clk) disable iff (rst)
        start_o |-> !en_q);
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
    import adc_bus_pkg::*;
#(
    parameter int CYC_PER_BIT = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  start_i,
    input  logic  a0_i,
    input  word_t sar_word_i,
    output logic  busy_o,
    output word_t result_o
);
    localparam int LONG_LEN  = conv_cycles(1'b0, CYC_PER_BIT);
    localparam int SHORT_LEN = conv_cycles(1'b1, CYC_PER_BIT);
    localparam int CNT_W     = $clog2(LONG_LEN + 1);
    localparam logic [CNT_W-1:0] LONG_LIM  = CNT_W'(LONG_LEN - 1);
    localparam logic [CNT_W-1:0] SHORT_LIM = CNT_W'(SHORT_LEN - 1);

    conv_st_e         st_q;
    logic [CNT_W-1:0] cnt_q;
    logic             short_q;
    word_t            result_q;
    logic [CNT_W-1:0] lim;
    logic             done;

    assign lim      = short_q ? SHORT_LIM : LONG_LIM;
    assign done     = (st_q == ST_CONV) && (cnt_q >= lim);
    assign busy_o   = (st_q == ST_CONV);
    assign result_o = result_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            cnt_q    <= '0;
            short_q  <= 1'b0;
            result_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (start_i) begin
                        st_q    <= ST_CONV;
                        cnt_q   <= '0;
                        short_q <= a0_i;
                    end
                end
                ST_CONV: begin
                    if (start_i) short_q <= a0_i;
                    if (done) begin
                        st_q     <= ST_IDLE;
                        cnt_q    <= '0;
                        result_q <= trim_short(sar_word_i, short_q);
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // R2: conversion only begins after a start request
    assert_rise_needs_start_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(start_i));
    // R4: a repeated start does not rewind the count
    assert_no_restart_R4: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i && !done) |=> (cnt_q == $past(cnt_q) + 1'b1));
    // R5: a repeated start re-latches the address bit
    assert_relatch_R5: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i) |=> (short_q == $past(a0_i)));
    // R10: a short result carries cleared low bits
    assert_short_trim_R10: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy_o) && short_q) |-> (result_q[NIB_W-1:0] == '0));
endmodule

// File: rtl/adc_out_mux.sv
module adc_out_mux
    import adc_bus_pkg::*;
(
    input  logic  en_i,
    input  logic  rc_i,
    input  logic  busy_i,
    input  logic  fmt12_i,
    input  logic  a0_i,
    input  word_t result_i,
    output logic  oe_o,
    output word_t dbus_o
);
    word_t view;

    always_comb begin
        view = '0;
        if (fmt12_i) begin
            view = result_i;
        end else if (!a0_i) begin
            view[DATA_W-1:NIB_W] = result_i[DATA_W-1:NIB_W];
        end else begin
            view[DATA_W-1:DATA_W-NIB_W] = result_i[NIB_W-1:0];
        end
    end

    assign oe_o   = rc_i & ~busy_i & en_i;
    assign dbus_o = oe_o ? view : '0;

    always_comb begin
        // R6: a byte read never places data in the low nibble
        assert_byte_low_zero_R6: assert (fmt12_i || (dbus_o[NIB_W-1:0] == '0));
    end
endmodule

// File: rtl/adc_bus_ctrl.sv
module adc_bus_ctrl
    import adc_bus_pkg::*;
#(
    parameter int CYC_PER_BIT = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_i,
    input  logic              cs_n_i,
    input  logic              rc_i,
    input  logic              a0_i,
    input  logic              fmt12_i,
    input  logic [DATA_W-1:0] sar_word_i,
    output logic              busy_o,
    output logic              oe_o,
    output logic [DATA_W-1:0] dbus_o
);
    logic  en;
    logic  start;
    word_t result;

    adc_en_edge u_edge (
        .clk     (clk),
        .rst     (rst),
        .ce_i    (ce_i),
        .cs_n_i  (cs_n_i),
        .rc_i    (rc_i),
        .en_o    (en),
        .start_o (start)
    );

    adc_conv_seq #(.CYC_PER_BIT(CYC_PER_BIT)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start),
        .a0_i       (a0_i),
        .sar_word_i (sar_word_i),
        .busy_o     (busy_o),
        .result_o   (result)
    );

    adc_out_mux u_mux (
        .en_i     (en),
        .rc_i     (rc_i),
        .busy_i   (busy_o),
        .fmt12_i  (fmt12_i),
        .a0_i     (a0_i),
        .result_i (result),
        .oe_o     (oe_o),
        .dbus_o   (dbus_o)
    );

    // R6: bus is never enabled during a conversion
    assert_no_read_busy_R6: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (!oe_o && dbus_o == '0));
    // R6: a disabled bus carries zero
    assert_idle_bus_zero_R6: assert property (@(posedge clk) disable iff (rst)
        !oe_o |-> (dbus_o == '0));
endmodule

// File: tb/test_adc_bus_ctrl.sv
module test_adc_bus_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int CPB        = 2;
    localparam int LONG_N     = 12 * CPB;
    localparam int SHORT_N    = 8 * CPB;

    // {word, short, fmt12, read_a0, expected}
    localparam logic [26:0] VEC [0:7] = '{
        {12'hABC, 1'b0, 1'b1, 1'b0, 12'hABC},
        {12'hABC, 1'b0, 1'b0, 1'b0, 12'hAB0},
        {12'hABC, 1'b0, 1'b0, 1'b1, 12'hC00},
        {12'h5A7, 1'b1, 1'b1, 1'b0, 12'h5A0},
        {12'h5A7, 1'b1, 1'b0, 1'b1, 12'h000},
        {12'hFFF, 1'b0, 1'b0, 1'b0, 12'hFF0},
        {12'h123, 1'b1, 1'b0, 1'b0, 12'h120},
        {12'h001, 1'b0, 1'b0, 1'b1, 12'h100}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce = 1'b0, cs_n = 1'b1, rc = 1'b0, a0 = 1'b0, fmt12 = 1'b1;
    logic [11:0] sar_word = '0;
    logic        busy, oe;
    logic [11:0] dbus;

    int total = 0;
    int bad   = 0;

    adc_bus_ctrl #(.CYC_PER_BIT(CPB)) i_adc_bus_ctrl (
        .clk(clk), .rst(rst), .ce_i(ce), .cs_n_i(cs_n), .rc_i(rc), .a0_i(a0),
        .fmt12_i(fmt12), .sar_word_i(sar_word), .busy_o(busy), .oe_o(oe), .dbus_o(dbus)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Start a conversion and return how many cycles busy stayed high.
    // At busy cycle 3 a second start edge with a0=a0_new is issued;
    // at cycle 6 a read is attempted, which must stay disabled.
    task automatic convert(input logic [11:0] word, input logic a0_start,
                           input logic retrig, input logic a0_new, output int n);
        @(negedge clk);
        sar_word = word; a0 = a0_start; rc = 1'b0; cs_n = 1'b0; ce = 1'b1;
        @(negedge clk);
        ce = 1'b0;
        n = 0;
        while (busy && n < 1000) begin
            n++;
            if (retrig && n == 3) begin a0 = a0_new; ce = 1'b1; end
            if (retrig && n == 4) ce = 1'b0;
            if (retrig && n == 6) begin
                rc = 1'b1; ce = 1'b1; #1;
                check("R6 oe busy", int'(oe), 0);
                check("R6 dbus busy", int'(dbus), 0);
            end
            if (retrig && n == 7) begin rc = 1'b0; ce = 1'b0; end
            @(negedge clk);
        end
        cs_n = 1'b1;
    endtask

    task automatic read(input logic f12, input logic ra0, output logic [11:0] d, output logic o);
        @(negedge clk);
        fmt12 = f12; a0 = ra0; rc = 1'b1; cs_n = 1'b0; ce = 1'b1;
        #1;
        d = dbus; o = oe;
        @(negedge clk);
        ce = 1'b0; cs_n = 1'b1; rc = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        logic [11:0] d;
        logic o;

        repeat (3) @(negedge clk);
        check("R1 busy in reset", int'(busy), 0);
        check("R1 oe in reset", int'(oe), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 busy after reset", int'(busy), 0);
        check("R1 dbus after reset", int'(dbus), 0);
        read(1'b1, 1'b0, d, o);
        check("R1 result after reset", int'(d), 0);

        // vector table walk
        foreach (VEC[i]) begin
            convert(VEC[i][26:15], VEC[i][14], 1'b0, 1'b0, n);
            check(VEC[i][14] ? "R3 short length" : "R3 long length",
                  n, VEC[i][14] ? SHORT_N : LONG_N);
            read(VEC[i][13], VEC[i][12], d, o);
            check("R6 oe on read", int'(o), 1);
            check(VEC[i][13] ? "R7 full read" : (VEC[i][12] ? "R9 low byte read" : "R8 high byte read"),
                  int'(d), int'(VEC[i][11:0]));
            if (VEC[i][14]) check("R10 short low bits", int'(d[3:0]), 0);
        end

        // R11: edge with rc high starts nothing
        @(negedge clk);
        rc = 1'b1; cs_n = 1'b0; ce = 1'b1;
        @(negedge clk);
        check("R11 no start on read edge", int'(busy), 0);
        ce = 1'b0; cs_n = 1'b1; rc = 1'b0;

        // R2: held enable does not start a second conversion
        @(negedge clk);
        a0 = 1'b1; cs_n = 1'b0; ce = 1'b1;
        @(negedge clk);
        check("R2 busy after edge", int'(busy), 1);
        repeat (SHORT_N) @(negedge clk);
        check("R2 held enable no restart", int'(busy), 0);
        ce = 1'b0; cs_n = 1'b1;

        // R6: each missing condition keeps the bus off
        @(negedge clk);
        rc = 1'b1; ce = 1'b1; cs_n = 1'b1; #1;
        check("R6 oe cs high", int'(oe), 0);
        check("R6 dbus cs high", int'(dbus), 0);
        cs_n = 1'b0; ce = 1'b0; #1;
        check("R6 oe ce low", int'(oe), 0);
        rc = 1'b0; ce = 1'b1; #1;
        check("R6 oe rc low", int'(oe), 0);
        @(negedge clk);
        ce = 1'b0; cs_n = 1'b1;
        @(negedge clk);
        if (busy) repeat (LONG_N + 2) @(negedge clk);

        // R4: restart edge with same a0 and a read attempt during busy
        convert(12'h3C5, 1'b0, 1'b1, 1'b0, n);
        check("R4 length unchanged", n, LONG_N);
        // R5: long start shortened by re-latch
        convert(12'h3C5, 1'b0, 1'b1, 1'b1, n);
        check("R5 relatch to short", n, SHORT_N);
        read(1'b1, 1'b0, d, o);
        check("R10 relatched short trims", int'(d), 12'h3C0);
        // R5: short start lengthened by re-latch
        convert(12'h3C5, 1'b1, 1'b1, 1'b0, n);
        check("R5 relatch to long", n, LONG_N);
        read(1'b1, 1'b0, d, o);
        check("R7 relatched long full", int'(d), 12'h3C5);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule